// File: doc/BRIEF.md
# J1850 Link Fault Recovery Controller

This block is the decision-making core between a J1850 symbol encoder/decoder and a host processor. The symbol layer passes up one-cycle pulses for start-of-frame, end-of-frame, bus idle, a received BREAK, a bad bit, a framing symbol that lands off a byte boundary, a failed CRC and a transmit-echo mismatch. It also passes a level that says the bus is stuck in its active state, and a symbol-period tick. The host requests transmissions and reads a state vector. The controller decides when a transmission may start and when it must be aborted. After each kind of fault it chooses where to resume: at the next end-of-frame, at bus idle followed by a fresh start-of-frame, or at the next host request.

Pending conditions are kept as three flags: invalid symbol, CRC error and end-of-frame. They are reported through a two-bit vector that shows the most urgent one. A host read of the vector clears only the source it reported. A separate sticky flag reports a stuck-active bus that lasts a programmable number of symbol periods. The controller never sends a BREAK. Once a bus fault goes away it recovers on its own, with no reset.

The FSM states, with `link_state` codes, are:
- IDLE=0: ready.
- RX=1: receiving a frame.
- TX=2: transmitting.
- WAIT_EOF=3: waiting for end-of-frame.
- WAIT_IDLE=4: waiting for bus idle.
- WAIT_SOF=5: waiting for a start-of-frame.
- STUCK=6: bus held active.

The transitions are:
- start-tx: IDLE→TX.
- frame-in: IDLE→RX and WAIT_SOF→RX.
- frame-done: RX/TX/WAIT_EOF→IDLE on EOF.
- symbol-fault: RX/TX→WAIT_EOF on a bad bit or an off-boundary framing symbol.
- crc-fault: RX/TX→WAIT_EOF.
- echo-abort: TX→IDLE.
- break-seen: RX/TX/WAIT_EOF→WAIT_IDLE.
- idle-seen: WAIT_IDLE→WAIT_SOF.
- stuck-entry: any non-STUCK state→STUCK.
- stuck-release: STUCK→WAIT_EOF.

Top module: `j1850_fault_ctrl`

## Requirements
- R1: After reset `link_state` is 0 (IDLE), and `state_vec`, `irq`, `tx_en`, `tx_abort` and `arb_lost` are all 0.
- R2: A `host_tx_req` pulse in IDLE gives `link_state`=2 and `tx_en`=1 one cycle later. A request made while the controller is not in IDLE is held. Transmission then starts one cycle after the controller next reaches IDLE.
- R3: An EOF during TX returns the controller to IDLE, sets the EOF flag (`state_vec`=1) and consumes the pending request, so no second transmission follows.
- R4: A bad bit or an off-boundary framing symbol during TX pulses `tx_abort` for one cycle. It also sets the invalid-symbol flag (`state_vec`=3) and moves to WAIT_EOF (3). The same events during RX do the same without `tx_abort`. A request held through such an abort is retried after recovery.
- R5: A CRC error during RX or TX sets the CRC flag (`state_vec`=2 when no invalid symbol is pending) and moves to WAIT_EOF. During TX it also pulses `tx_abort`.
- R6: A transmit-echo mismatch during TX pulses `tx_abort`, sets the invalid-symbol flag and returns to IDLE with the request dropped. No transmission starts until a new `host_tx_req`.
- R7: A BREAK during RX or TX (TX also pulses `tx_abort`) sets the invalid-symbol flag and moves to WAIT_IDLE (4). `ev_idle` then moves it to WAIT_SOF (5), and `ev_sof` moves it to RX. Host requests do not start a transmission in these states.
- R8: While `bus_stuck_hi` is 1 the controller is in STUCK (6) with `tx_en`=0. Entering STUCK sets the invalid-symbol flag, and entering it from TX pulses `tx_abort`. On release it goes to WAIT_EOF, and only after an EOF may a held request transmit.
- R9: While in STUCK, once `stuck_limit` `sym_tick` pulses (limit nonzero) have arrived, `arb_lost` becomes 1 and stays set until a `vec_rd` pulse.
- R10: `state_vec` shows the highest pending source: 3 invalid symbol, then 2 CRC, then 1 EOF, 0 none. `irq` is 1 exactly when `state_vec` is nonzero.
- R11: A `vec_rd` pulse clears only the source that `state_vec` showed in that cycle. Lower sources remain and are reported next.
- R12: In WAIT_EOF an EOF moves the controller to IDLE and sets the EOF flag.
- R13: Error and end events that have no meaning in the current state, such as `ev_crc_bad` or `ev_eof` in IDLE, leave `link_state` and `state_vec` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sof | input | 1 | Start-of-frame seen (pulse) |
| ev_eof | input | 1 | End-of-frame seen (pulse) |
| ev_idle | input | 1 | Bus idle seen (pulse) |
| ev_break | input | 1 | BREAK symbol received (pulse) |
| ev_bad_bit | input | 1 | Invalid bit received (pulse) |
| ev_frame_off | input | 1 | Framing symbol off a byte boundary (pulse) |
| ev_crc_bad | input | 1 | CRC check failed (pulse) |
| ev_echo_err | input | 1 | Transmitted bit not echoed on the bus (pulse) |
| bus_stuck_hi | input | 1 | Bus held in the active state (level) |
| sym_tick | input | 1 | One symbol period elapsed (pulse) |
| stuck_limit | input | CNT_W | Symbol periods of stuck bus before `arb_lost` |
| host_tx_req | input | 1 | Host transmit command (pulse) |
| vec_rd | input | 1 | Host read of the state vector (pulse) |
| tx_en | output | 1 | Transmitter enabled |
| tx_abort | output | 1 | Transmission aborted (one-cycle pulse) |
| irq | output | 1 | Any source pending |
| state_vec | output | 2 | Highest-priority pending source code |
| arb_lost | output | 1 | Sticky long-stuck-bus flag |
| link_state | output | 3 | Current FSM state code |

## Verification
On every cycle the assertions check several per-transition rules. A transmission can only begin from IDLE. An echo mismatch always lands in IDLE with the request dropped. CRC and BREAK faults reach their own wait states. A stuck bus holds the STUCK state. A fresh invalid-symbol set always shows as vector 3. A read of the CRC code removes that flag. `arb_lost` never rises off the stuck state. Only the directed scenarios show complete recovery sequences across several events. These cover the retry that follows an ordinary abort against no retry after an echo mismatch, and the idle-then-SOF path after a BREAK. They also cover the EOF needed after a stuck bus clears, the count to `arb_lost`, and the order in which successive reads drain the vector.

// File: rtl/j1850_fault_pkg.sv
package j1850_fault_pkg;
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_RX        = 3'd1,
        S_TX        = 3'd2,
        S_WAIT_EOF  = 3'd3,
        S_WAIT_IDLE = 3'd4,
        S_WAIT_SOF  = 3'd5,
        S_STUCK     = 3'd6
    } link_st_t;

    localparam logic [1:0] VEC_NONE = 2'd0;
    localparam logic [1:0] VEC_EOF  = 2'd1;
    localparam logic [1:0] VEC_CRC  = 2'd2;
    localparam logic [1:0] VEC_INV  = 2'd3;
endpackage

// File: rtl/j1850_link_fsm.sv
module j1850_link_fsm
    import j1850_fault_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ev_sof,
    input  logic     ev_eof,
    input  logic     ev_idle,
    input  logic     ev_break,
    input  logic     ev_bad_bit,
    input  logic     ev_frame_off,
    input  logic     ev_crc_bad,
    input  logic     ev_echo_err,
    input  logic     bus_stuck_hi,
    input  logic     host_tx_req,
    output link_st_t state,
    output logic     tx_pend,
    output logic     tx_abort,
    output logic     set_inv,
    output logic     set_crc,
    output logic     set_eof
);
    link_st_t nxt;
    logic     abort_now;
    logic     pend_clr;

    always_comb begin
        nxt       = state;
        set_inv   = 1'b0;
        set_crc   = 1'b0;
        set_eof   = 1'b0;
        abort_now = 1'b0;
        pend_clr  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (bus_stuck_hi) begin
                    nxt = S_STUCK; set_inv = 1'b1;
                end else if (ev_sof) begin
                    nxt = S_RX;
                end else if (tx_pend || host_tx_req) begin
                    nxt = S_TX;
                end
            end
            S_RX: begin
                if (bus_stuck_hi) begin
                    nxt = S_STUCK; set_inv = 1'b1;
                end else if (ev_break) begin
                    nxt = S_WAIT_IDLE; set_inv = 1'b1;
                end else if (ev_bad_bit || ev_frame_off) begin
                    nxt = S_WAIT_EOF; set_inv = 1'b1;
                end else if (ev_crc_bad) begin
                    nxt = S_WAIT_EOF; set_crc = 1'b1;
                end else if (ev_eof) begin
                    nxt = S_IDLE; set_eof = 1'b1;
                end
            end
            S_TX: begin
                if (bus_stuck_hi) begin
                    nxt = S_STUCK; set_inv = 1'b1; abort_now = 1'b1;
                end else if (ev_echo_err) begin
                    nxt = S_IDLE; set_inv = 1'b1; abort_now = 1'b1; pend_clr = 1'b1;
                end else if (ev_break) begin
                    nxt = S_WAIT_IDLE; set_inv = 1'b1; abort_now = 1'b1;
                end else if (ev_bad_bit || ev_frame_off) begin
                    nxt = S_WAIT_EOF; set_inv = 1'b1; abort_now = 1'b1;
                end else if (ev_crc_bad) begin
                    nxt = S_WAIT_EOF; set_crc = 1'b1; abort_now = 1'b1;
                end else if (ev_eof) begin
                    nxt = S_IDLE; set_eof = 1'b1; pend_clr = 1'b1;
                end
            end
            S_WAIT_EOF: begin
                if (bus_stuck_hi) begin
                    nxt = S_STUCK; set_inv = 1'b1;
                end else if (ev_break) begin
                    nxt = S_WAIT_IDLE; set_inv = 1'b1;
                end else if (ev_eof) begin
                    nxt = S_IDLE; set_eof = 1'b1;
                end
            end
            S_WAIT_IDLE: begin
                if (bus_stuck_hi) begin
                    nxt = S_STUCK; set_inv = 1'b1;
                end else if (ev_idle) begin
                    nxt = S_WAIT_SOF;
                end
            end
            S_WAIT_SOF: begin
                if (bus_stuck_hi) begin
                    nxt = S_STUCK; set_inv = 1'b1;
                end else if (ev_sof) begin
                    nxt = S_RX;
                end
            end
            S_STUCK: begin
                if (!bus_stuck_hi) nxt = S_WAIT_EOF;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tx_pend  <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            state    <= nxt;
            tx_abort <= abort_now;
            if (pend_clr)
                tx_pend <= 1'b0;
            else if (host_tx_req && state != S_TX)
                tx_pend <= 1'b1;
        end
    end

    // R2
    tx_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_TX) |=> state != S_TX);

    // R6
    echo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TX && ev_echo_err && !bus_stuck_hi) |=> (state == S_IDLE && !tx_pend));

    // R5
    crc_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_RX || state == S_TX) && ev_crc_bad && !bus_stuck_hi) |=> state == S_WAIT_EOF);

    // R7
    break_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_RX || state == S_TX) && ev_break && !bus_stuck_hi) |=> state == S_WAIT_IDLE);

    // R8
    stuck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STUCK && bus_stuck_hi) |=> state == S_STUCK);
endmodule

// File: rtl/j1850_irq_vec.sv
module j1850_irq_vec
    import j1850_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_inv,
    input  logic       set_crc,
    input  logic       set_eof,
    input  logic       vec_rd,
    output logic [1:0] vec,
    output logic       irq
);
    logic inv_q, crc_q, eof_q;

    always_comb begin
        if (inv_q)      vec = VEC_INV;
        else if (crc_q) vec = VEC_CRC;
        else if (eof_q) vec = VEC_EOF;
        else            vec = VEC_NONE;
        irq = (vec != VEC_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
            crc_q <= 1'b0;
            eof_q <= 1'b0;
        end else begin
            inv_q <= set_inv | (inv_q & ~(vec_rd && vec == VEC_INV));
            crc_q <= set_crc | (crc_q & ~(vec_rd && vec == VEC_CRC));
            eof_q <= set_eof | (eof_q & ~(vec_rd && vec == VEC_EOF));
        end
    end

    // R10
    inv_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_inv |=> vec == VEC_INV);

    // R11
    crc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && vec == VEC_CRC && !set_crc) |=> !crc_q);
endmodule

// File: rtl/j1850_stuck_timer.sv
module j1850_stuck_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stuck,
    input  logic             sym_tick,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr,
    output logic             arb_lost
);
    logic [CNT_W-1:0] cnt;
    logic             hit;

    always_comb hit = stuck && sym_tick && (cnt != limit) && ((cnt + 1'b1) == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            arb_lost <= 1'b0;
        end else begin
            if (!stuck)
                cnt <= '0;
            else if (sym_tick && cnt != limit)
                cnt <= cnt + 1'b1;
            arb_lost <= hit | (arb_lost & ~clr);
        end
    end

    // R9
    arb_only_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stuck && !arb_lost) |=> !arb_lost);
endmodule

// File: rtl/j1850_fault_ctrl.sv
module j1850_fault_ctrl
    import j1850_fault_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_sof,
    input  logic             ev_eof,
    input  logic             ev_idle,
    input  logic             ev_break,
    input  logic             ev_bad_bit,
    input  logic             ev_frame_off,
    input  logic             ev_crc_bad,
    input  logic             ev_echo_err,
    input  logic             bus_stuck_hi,
    input  logic             sym_tick,
    input  logic [CNT_W-1:0] stuck_limit,
    input  logic             host_tx_req,
    input  logic             vec_rd,
    output logic             tx_en,
    output logic             tx_abort,
    output logic             irq,
    output logic [1:0]       state_vec,
    output logic             arb_lost,
    output logic [2:0]       link_state
);
    link_st_t st;
    logic     pend, s_inv, s_crc, s_eof;

    j1850_link_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_idle(ev_idle), .ev_break(ev_break),
        .ev_bad_bit(ev_bad_bit), .ev_frame_off(ev_frame_off), .ev_crc_bad(ev_crc_bad),
        .ev_echo_err(ev_echo_err), .bus_stuck_hi(bus_stuck_hi), .host_tx_req(host_tx_req),
        .state(st), .tx_pend(pend), .tx_abort(tx_abort),
        .set_inv(s_inv), .set_crc(s_crc), .set_eof(s_eof)
    );

    j1850_irq_vec u_vec (
        .clk(clk), .rst_n(rst_n),
        .set_inv(s_inv), .set_crc(s_crc), .set_eof(s_eof),
        .vec_rd(vec_rd), .vec(state_vec), .irq(irq)
    );

    j1850_stuck_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .stuck(st == S_STUCK), .sym_tick(sym_tick), .limit(stuck_limit),
        .clr(vec_rd), .arb_lost(arb_lost)
    );

    assign tx_en      = (st == S_TX);
    assign link_state = st;

    logic unused_pend;
    assign unused_pend = pend;
endmodule

// File: tb/j1850_fault_ctrl_tb.sv
module j1850_fault_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_sof = 0, ev_eof = 0, ev_idle = 0, ev_break = 0, ev_bad_bit = 0;
    logic ev_frame_off = 0, ev_crc_bad = 0, ev_echo_err = 0, bus_stuck_hi = 0;
    logic sym_tick = 0, host_tx_req = 0, vec_rd = 0;
    logic [7:0] stuck_limit = 8'd3;
    logic tx_en, tx_abort, irq, arb_lost;
    logic [1:0] state_vec;
    logic [2:0] link_state;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    j1850_fault_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_idle(ev_idle),
        .ev_break(ev_break), .ev_bad_bit(ev_bad_bit), .ev_frame_off(ev_frame_off),
        .ev_crc_bad(ev_crc_bad), .ev_echo_err(ev_echo_err), .bus_stuck_hi(bus_stuck_hi),
        .sym_tick(sym_tick), .stuck_limit(stuck_limit), .host_tx_req(host_tx_req),
        .vec_rd(vec_rd), .tx_en(tx_en), .tx_abort(tx_abort), .irq(irq),
        .state_vec(state_vec), .arb_lost(arb_lost), .link_state(link_state)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd();
        vec_rd = 1; tick(); vec_rd = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) if (state_vec != 0) rd();
        if (arb_lost) rd();
    endtask

    task automatic t_reset();
        chk("R1 state", link_state, 0); chk("R1 vec", state_vec, 0);
        chk("R1 irq", irq, 0); chk("R1 tx_en", tx_en, 0);
        chk("R1 abort", tx_abort, 0); chk("R1 arb", arb_lost, 0);
    endtask

    task automatic t_tx_ok();
        host_tx_req = 1; tick(); host_tx_req = 0;
        chk("R2 tx state", link_state, 2); chk("R2 tx_en", tx_en, 1);
        ev_eof = 1; tick(); ev_eof = 0;
        chk("R3 idle", link_state, 0); chk("R3 eof vec", state_vec, 1); chk("R10 irq", irq, 1);
        tick(); chk("R3 no retx", link_state, 0);
        rd(); chk("R11 eof cleared", state_vec, 0); chk("R10 irq low", irq, 0);
    endtask

    task automatic t_pend_rx();
        ev_sof = 1; tick(); ev_sof = 0; chk("R2 rx", link_state, 1);
        host_tx_req = 1; tick(); host_tx_req = 0; chk("R2 held", link_state, 1);
        ev_eof = 1; tick(); ev_eof = 0; chk("R2 idle first", link_state, 0);
        tick(); chk("R2 pending starts", link_state, 2);
        ev_eof = 1; tick(); ev_eof = 0; chk("R3 done", link_state, 0);
        drain();
    endtask

    task automatic t_tx_badbit();
        host_tx_req = 1; tick(); host_tx_req = 0;
        ev_bad_bit = 1; tick(); ev_bad_bit = 0;
        chk("R4 abort", tx_abort, 1); chk("R4 wait_eof", link_state, 3); chk("R4 vec", state_vec, 3);
        tick(); chk("R4 abort one cycle", tx_abort, 0);
        ev_eof = 1; tick(); ev_eof = 0;
        chk("R12 idle", link_state, 0); chk("R10 inv over eof", state_vec, 3);
        tick(); chk("R4 retry", link_state, 2);
        ev_eof = 1; tick(); ev_eof = 0;
        drain();
    endtask

    task automatic t_rx_frame();
        ev_sof = 1; tick(); ev_sof = 0;
        ev_frame_off = 1; tick(); ev_frame_off = 0;
        chk("R4 rx no abort", tx_abort, 0); chk("R4 rx wait_eof", link_state, 3);
        chk("R4 rx vec", state_vec, 3);
        ev_eof = 1; tick(); ev_eof = 0; chk("R12 rx idle", link_state, 0);
        drain();
    endtask

    task automatic t_crc();
        ev_sof = 1; tick(); ev_sof = 0;
        ev_crc_bad = 1; tick(); ev_crc_bad = 0;
        chk("R5 wait_eof", link_state, 3); chk("R5 vec", state_vec, 2); chk("R5 no abort", tx_abort, 0);
        ev_eof = 1; tick(); ev_eof = 0;
        chk("R12 idle", link_state, 0); chk("R10 crc over eof", state_vec, 2);
        rd(); chk("R11 eof remains", state_vec, 1);
        rd(); chk("R11 empty", state_vec, 0);
        host_tx_req = 1; tick(); host_tx_req = 0;
        ev_crc_bad = 1; tick(); ev_crc_bad = 0;
        chk("R5 tx abort", tx_abort, 1); chk("R5 tx wait_eof", link_state, 3);
        ev_eof = 1; tick(); ev_eof = 0; tick();
        ev_eof = 1; tick(); ev_eof = 0;
        drain();
    endtask

    task automatic t_echo();
        host_tx_req = 1; tick(); host_tx_req = 0;
        ev_echo_err = 1; tick(); ev_echo_err = 0;
        chk("R6 abort", tx_abort, 1); chk("R6 idle", link_state, 0); chk("R6 vec", state_vec, 3);
        tick(); tick(); chk("R6 no retry", link_state, 0); chk("R6 tx_en", tx_en, 0);
        drain();
    endtask

    task automatic t_break();
        ev_sof = 1; tick(); ev_sof = 0;
        ev_break = 1; tick(); ev_break = 0;
        chk("R7 wait_idle", link_state, 4); chk("R7 vec", state_vec, 3);
        host_tx_req = 1; tick(); host_tx_req = 0; chk("R7 no tx", link_state, 4);
        ev_eof = 1; tick(); ev_eof = 0; chk("R7 eof ignored", link_state, 4);
        ev_idle = 1; tick(); ev_idle = 0; chk("R7 wait_sof", link_state, 5);
        tick(); chk("R7 still wait_sof", link_state, 5);
        ev_sof = 1; tick(); ev_sof = 0; chk("R7 rx", link_state, 1);
        ev_eof = 1; tick(); ev_eof = 0; tick(); chk("R7 held tx", link_state, 2);
        ev_break = 1; tick(); ev_break = 0;
        chk("R7 tx abort", tx_abort, 1); chk("R7 tx wait_idle", link_state, 4);
        ev_idle = 1; tick(); ev_idle = 0; ev_sof = 1; tick(); ev_sof = 0;
        ev_eof = 1; tick(); ev_eof = 0; tick();
        ev_eof = 1; tick(); ev_eof = 0;
        drain();
    endtask

    task automatic t_stuck();
        stuck_limit = 8'd3;
        bus_stuck_hi = 1; tick();
        chk("R8 stuck", link_state, 6); chk("R8 vec", state_vec, 3); chk("R8 tx_en", tx_en, 0);
        host_tx_req = 1; tick(); host_tx_req = 0; chk("R8 no tx", link_state, 6);
        sym_tick = 1; tick(); tick(); sym_tick = 0; tick();
        chk("R9 not yet", arb_lost, 0);
        sym_tick = 1; tick(); sym_tick = 0;
        chk("R9 arb set", arb_lost, 1);
        bus_stuck_hi = 0; tick(); chk("R8 wait_eof", link_state, 3);
        tick(); chk("R8 still waiting", link_state, 3);
        chk("R9 sticky", arb_lost, 1);
        ev_eof = 1; tick(); ev_eof = 0; chk("R8 idle", link_state, 0);
        tick(); chk("R8 held tx", link_state, 2);
        bus_stuck_hi = 1; tick();
        chk("R8 tx abort", tx_abort, 1); chk("R8 from tx", link_state, 6);
        bus_stuck_hi = 0; tick();
        ev_eof = 1; tick(); ev_eof = 0; tick();
        ev_eof = 1; tick(); ev_eof = 0;
        rd(); chk("R9 cleared by read", arb_lost, 0);
        drain();
    endtask

    task automatic t_ignore();
        ev_crc_bad = 1; tick(); ev_crc_bad = 0;
        chk("R13 state", link_state, 0); chk("R13 vec", state_vec, 0);
        ev_eof = 1; tick(); ev_eof = 0;
        chk("R13 eof state", link_state, 0); chk("R13 eof vec", state_vec, 0);
    endtask

    task automatic t_prio();
        ev_sof = 1; tick(); ev_sof = 0;
        ev_crc_bad = 1; tick(); ev_crc_bad = 0;
        ev_break = 1; tick(); ev_break = 0;
        chk("R10 inv top", state_vec, 3);
        rd(); chk("R11 crc next", state_vec, 2);
        rd(); chk("R11 none", state_vec, 0);
        ev_idle = 1; tick(); ev_idle = 0; ev_sof = 1; tick(); ev_sof = 0;
        ev_eof = 1; tick(); ev_eof = 0;
        drain();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        t_reset();
        t_tx_ok();
        t_pend_rx();
        t_tx_badbit();
        t_rx_frame();
        t_crc();
        t_echo();
        t_break();
        t_stuck();
        t_ignore();
        t_prio();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule